// File: doc/BRIEF.md
# SPI NAND Page Read Sequencer

This block serves read requests against a serial NAND flash device whose on-chip error correction is switched on. A request gives a starting byte offset and a byte count. Both must be whole multiples of the 2048-byte page. The sequencer works through the request one page at a time. For each page it polls the device until it is no longer busy, has the device copy the page into its internal buffer, and polls again until that copy has finished. It then clocks the buffer out with a buffered fast read and hands every received byte to a valid/ready output stream. Finally it reads the device's ECC status to decide whether the page is good. The request ends with a one-cycle `done`, and `err` is raised alongside `done` when the request was misaligned or a page could not be corrected.

The device is reached through a byte-transaction port. `spi_cs_n` frames each transaction. The sequencer raises `byte_req` with a transmit byte on `byte_tx` and holds both until the byte engine answers with a one-cycle `byte_ack`, which carries the byte received in the same slot on `byte_rx`. Between two transactions chip select is released for at least one cycle.

Control is one state machine with these states. `ST_IDLE` accepts requests. `ST_POLL_PRE` is the busy poll before a load, `ST_LOAD` the page-load command and `ST_POLL_POST` the busy poll after the load. `ST_RD_HDR` sends the header of the buffered read. `ST_RD_DATA` fetches one data byte and `ST_RD_HOLD` offers it on the stream. `ST_ECC` is the status read for ECC. `ST_GAP` is a chip-select-high cycle between transactions and `ST_FINISH` is the done cycle. The transitions are:
- IDLE to FINISH on a misaligned or empty request, and IDLE to POLL_PRE otherwise.
- Each poll state repeats itself through GAP while the busy bit is set. Once the bit is clear, POLL_PRE moves through GAP to LOAD, and POLL_POST moves through GAP to RD_HDR.
- LOAD moves through GAP to POLL_POST.
- RD_HDR moves to RD_DATA. RD_DATA moves to RD_HOLD. RD_HOLD goes back to RD_DATA, or after the last byte moves through GAP to ECC.
- ECC moves to FINISH on an uncorrectable page or after the final page. Otherwise it moves through GAP to POLL_PRE.
- FINISH returns to IDLE.

Top module: `spi_nand_page_reader`

## Requirements
- R1: If the offset or the count is not a multiple of 2048 (any of bits 10:0 set), the request ends with `done` and `err` both high in the cycle after acceptance, and no SPI traffic is generated (`spi_cs_n` stays high and `byte_req` stays low).
- R2: A request with count zero and an aligned offset ends with `done` high and `err` low, with no SPI traffic.
- R3: A busy poll is one transaction of the 3 bytes 0x05, 0xC0, 0x00. Busy is bit 0 of the byte received in the third slot. The poll is repeated, with `spi_cs_n` high for at least one cycle between transactions, until that bit reads 0.
- R4: The page-load transaction sends 0x13, then 0x00, then the page index high byte, then the page index low byte. The first page index is offset/2048, and the index increments by one for each following page.
- R5: For every page the transactions come in this order: busy poll(s), page load, busy poll(s), buffered read, ECC status read. The next page starts only after the ECC read.
- R6: The buffered read sends 0x0B, 0x00, 0x00, 0x00 and then min(remaining count, 2048) data slots with transmit byte 0x00, all in one transaction.
- R7: Each received data byte appears on `out_data` with `out_valid` high. It is held unchanged while `out_ready` is low, and no further SPI byte is requested until the byte has been accepted.
- R8: The ECC status is bits 5:4 of the third received byte of the status read that follows the data. The values 0 and 1 pass. The values 2 and 3 end the request with `done` and `err` high, no further page is read, and the bytes already streamed are not withdrawn.
- R9: `done` is a single-cycle pulse that ends every accepted request, and `err` is only ever high in the `done` cycle.
- R10: `req_ready` is high only when the sequencer is idle. A `req_valid` asserted while a request is in progress has no effect on the SPI traffic or the stream.
- R11: After reset `spi_cs_n` is high, `req_ready` is high, and `out_valid`, `byte_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when both high |
| req_offset | input | OFF_W (27) | Starting byte offset |
| req_count | input | CNT_W (24) | Number of bytes to read |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request failed, valid with done |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Stream consumer accepts the byte |
| out_data | output | 8 | Stream byte |
| spi_cs_n | output | 1 | Transaction frame, active low |
| byte_req | output | 1 | Byte slot requested from the engine |
| byte_tx | output | 8 | Byte to transmit in the slot |
| byte_ack | input | 1 | Engine completed the slot |
| byte_rx | input | 8 | Byte received in the slot |

## Verification
The bench aims at four corner cases. The first is a device that reports busy for several polls both before and after the load; a sequencer that skipped a repeat would issue the load or read too early, which shows up as a missing poll in the logged byte sequence. The second is a run of pages whose index crosses from 0x01FF to 0x0200; it exposes a wrong byte order or a lost carry in the page-load address. The third is ECC failure with code 2 and with code 3, in the middle of a request and on its first page; a design that decoded only one ECC bit, or that kept going, would end without `err` or would issue the next page's poll. The last is stream back-pressure combined with a slow byte engine; a sequencer that fetched ahead or dropped the held byte would put a mismatched or missing byte on the stream.

// File: rtl/snr_pkg.sv
package snr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_PRE,
        ST_LOAD,
        ST_POLL_POST,
        ST_RD_HDR,
        ST_RD_DATA,
        ST_RD_HOLD,
        ST_ECC,
        ST_GAP,
        ST_FINISH
    } snr_state_e;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_STATUS,
        CK_LOAD,
        CK_READ
    } snr_cmd_e;

    localparam logic [7:0] OP_GET_STATUS = 8'h05;
    localparam logic [7:0] OP_PAGE_LOAD  = 8'h13;
    localparam logic [7:0] OP_BUF_READ   = 8'h0B;
    localparam logic [7:0] REG_GENERAL   = 8'hC0;

endpackage

// File: rtl/snr_align_chk.sv
module snr_align_chk #(
    parameter int PAGE_LOG2 = 11,
    parameter int IDX_W     = 16,
    parameter int CNT_W     = 24,
    parameter int OFF_W     = IDX_W + PAGE_LOG2
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [CNT_W-1:0] count,
    output logic             aligned,
    output logic             empty,
    output logic [IDX_W-1:0] first_idx
);
    // page size is a power of two, so alignment is a test of the low bits
    always_comb begin
        aligned   = (offset[PAGE_LOG2-1:0] == '0) && (count[PAGE_LOG2-1:0] == '0);
        empty     = (count == '0);
        first_idx = offset[OFF_W-1:PAGE_LOG2];
    end
endmodule

// File: rtl/snr_cmd_gen.sv
module snr_cmd_gen
    import snr_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  snr_cmd_e         kind,
    input  logic [1:0]       pos,
    input  logic [IDX_W-1:0] page,
    output logic [7:0]       tx,
    output logic             last
);
    logic [15:0] pg16;

    always_comb begin
        pg16 = 16'(page);
        tx   = 8'h00;
        last = 1'b0;
        unique case (kind)
            CK_STATUS: begin
                last = (pos == 2'd2);
                unique case (pos)
                    2'd0:    tx = OP_GET_STATUS;
                    2'd1:    tx = REG_GENERAL;
                    default: tx = 8'h00;
                endcase
            end
            CK_LOAD: begin
                last = (pos == 2'd3);
                unique case (pos)
                    2'd0:    tx = OP_PAGE_LOAD;
                    2'd1:    tx = 8'h00;
                    2'd2:    tx = pg16[15:8];
                    default: tx = pg16[7:0];
                endcase
            end
            CK_READ: begin
                last = (pos == 2'd3);
                tx   = (pos == 2'd0) ? OP_BUF_READ : 8'h00;
            end
            default: begin
                tx   = 8'h00;
                last = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/snr_chunk.sv
module snr_chunk #(
    parameter int CNT_W      = 24,
    parameter int PAGE_BYTES = 2048
) (
    input  logic [CNT_W-1:0] remaining,
    output logic [CNT_W-1:0] chunk,
    output logic             final_page
);
    localparam logic [CNT_W-1:0] PAGE_C = CNT_W'(PAGE_BYTES);

    always_comb begin
        final_page = (remaining <= PAGE_C);
        chunk      = final_page ? remaining : PAGE_C;
    end
endmodule

// File: rtl/spi_nand_page_reader.sv
module spi_nand_page_reader
    import snr_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int IDX_W      = 16,
    parameter int CNT_W      = 24,
    parameter int OFF_W      = IDX_W + $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [CNT_W-1:0] req_count,
    output logic             done,
    output logic             err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             spi_cs_n,
    output logic             byte_req,
    output logic [7:0]       byte_tx,
    input  logic             byte_ack,
    input  logic [7:0]       byte_rx
);
    localparam int PAGE_LOG2 = $clog2(PAGE_BYTES);
    localparam int DL_W      = $clog2(PAGE_BYTES + 1);
    localparam logic [DL_W-1:0] ONE_LEFT = DL_W'(1);

    snr_state_e state, nxt, gap_q, gap_nxt;

    logic [IDX_W-1:0] page_q;
    logic [CNT_W-1:0] remain_q;
    logic [DL_W-1:0]  left_q;
    logic [1:0]       pos_q;
    logic [7:0]       data_q;
    logic             err_q;

    logic             aligned, empty;
    logic [IDX_W-1:0] first_idx;
    logic [CNT_W-1:0] chunk;
    logic             final_page;
    snr_cmd_e         kind;
    logic [7:0]       cmd_tx;
    logic             cmd_last;
    logic             rx_busy, rx_ecc_bad;
    logic             unused_rx;

    assign rx_busy    = byte_rx[0];
    assign rx_ecc_bad = byte_rx[5];   // ECC codes 2 and 3 both have bit 5 set
    assign unused_rx  = ^{byte_rx[7:6], byte_rx[4], byte_rx[3:1]};

    snr_align_chk #(
        .PAGE_LOG2 (PAGE_LOG2),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W),
        .OFF_W     (OFF_W)
    ) i_align (
        .offset    (req_offset),
        .count     (req_count),
        .aligned   (aligned),
        .empty     (empty),
        .first_idx (first_idx)
    );

    snr_chunk #(
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) i_chunk (
        .remaining  (remain_q),
        .chunk      (chunk),
        .final_page (final_page)
    );

    always_comb begin
        unique case (state)
            ST_POLL_PRE, ST_POLL_POST, ST_ECC: kind = CK_STATUS;
            ST_LOAD:                           kind = CK_LOAD;
            ST_RD_HDR:                         kind = CK_READ;
            default:                           kind = CK_NONE;
        endcase
    end

    snr_cmd_gen #(
        .IDX_W (IDX_W)
    ) i_cmd (
        .kind  (kind),
        .pos   (pos_q),
        .page  (page_q),
        .tx    (cmd_tx),
        .last  (cmd_last)
    );

    // next-state logic
    always_comb begin
        nxt     = state;
        gap_nxt = gap_q;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt = (!aligned || empty) ? ST_FINISH : ST_POLL_PRE;
                end
            end
            ST_POLL_PRE: begin
                if (byte_ack && cmd_last) begin
                    nxt     = ST_GAP;
                    gap_nxt = rx_busy ? ST_POLL_PRE : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (byte_ack && cmd_last) begin
                    nxt     = ST_GAP;
                    gap_nxt = ST_POLL_POST;
                end
            end
            ST_POLL_POST: begin
                if (byte_ack && cmd_last) begin
                    nxt     = ST_GAP;
                    gap_nxt = rx_busy ? ST_POLL_POST : ST_RD_HDR;
                end
            end
            ST_RD_HDR: begin
                if (byte_ack && cmd_last) nxt = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (byte_ack) nxt = ST_RD_HOLD;
            end
            ST_RD_HOLD: begin
                if (out_ready) begin
                    if (left_q == ONE_LEFT) begin
                        nxt     = ST_GAP;
                        gap_nxt = ST_ECC;
                    end else begin
                        nxt = ST_RD_DATA;
                    end
                end
            end
            ST_ECC: begin
                if (byte_ack && cmd_last) begin
                    if (rx_ecc_bad || final_page) begin
                        nxt = ST_FINISH;
                    end else begin
                        nxt     = ST_GAP;
                        gap_nxt = ST_POLL_PRE;
                    end
                end
            end
            ST_GAP:    nxt = gap_q;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            gap_q <= ST_IDLE;
        end else begin
            state <= nxt;
            gap_q <= gap_nxt;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            remain_q <= '0;
            left_q   <= '0;
            pos_q    <= '0;
            data_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        page_q   <= first_idx;
                        remain_q <= req_count;
                        err_q    <= !aligned;
                        pos_q    <= '0;
                    end
                end
                ST_POLL_PRE, ST_LOAD, ST_POLL_POST, ST_RD_HDR: begin
                    if (byte_ack) begin
                        pos_q <= cmd_last ? 2'd0 : pos_q + 2'd1;
                        if (state == ST_RD_HDR && cmd_last) left_q <= DL_W'(chunk);
                    end
                end
                ST_RD_DATA: begin
                    if (byte_ack) data_q <= byte_rx;
                end
                ST_RD_HOLD: begin
                    if (out_ready) left_q <= left_q - ONE_LEFT;
                end
                ST_ECC: begin
                    if (byte_ack) begin
                        pos_q <= cmd_last ? 2'd0 : pos_q + 2'd1;
                        if (cmd_last) begin
                            if (rx_ecc_bad) begin
                                err_q <= 1'b1;
                            end else begin
                                remain_q <= remain_q - chunk;
                                page_q   <= page_q + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        spi_cs_n  = (state == ST_IDLE) || (state == ST_GAP) || (state == ST_FINISH);
        byte_req  = (kind != CK_NONE) || (state == ST_RD_DATA);
        byte_tx   = (state == ST_RD_DATA) ? 8'h00 : cmd_tx;
        out_valid = (state == ST_RD_HOLD);
        out_data  = data_q;
        done      = (state == ST_FINISH);
        err       = (state == ST_FINISH) && err_q;
    end

    // R7: held stream byte stays put until taken
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R7: no SPI byte is requested while a stream byte waits
    a_r7_no_fetch_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !byte_req);

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an accepted request closes the request port
    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R3: byte slots only inside a chip-select frame
    a_r3_slot_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> !spi_cs_n);

    // R1: misaligned offset rejected at once
    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_offset[PAGE_LOG2-1:0] != '0) |=> done && err && spi_cs_n);

    // R8: uncorrectable ECC code ends the request with an error
    a_r8_ecc_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ECC) && byte_ack && cmd_last && byte_rx[5] |=> done && err);

endmodule

// File: tb/test_spi_nand_page_reader.sv
`timescale 1ns/1ps
module test_spi_nand_page_reader;
    localparam int PG    = 2048;
    localparam int IDX_W = 16;
    localparam int CNT_W = 24;
    localparam int OFF_W = 27;
    localparam int MARK  = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [OFF_W-1:0] req_offset = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic             done, err, out_valid;
    logic             out_ready = 1'b1;
    logic [7:0]       out_data;
    logic             spi_cs_n, byte_req;
    logic [7:0]       byte_tx;
    logic             byte_ack = 1'b0;
    logic [7:0]       byte_rx = 8'h00;

    spi_nand_page_reader i_spi_nand_page_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_count(req_count), .done(done), .err(err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .spi_cs_n(spi_cs_n), .byte_req(byte_req), .byte_tx(byte_tx),
        .byte_ack(byte_ack), .byte_rx(byte_rx)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;

    // device and environment configuration
    int busy_left = 0;
    int fail_pg = -1;
    int fail_code = 2;
    int corr_pg = -1;
    int rdy_mode = 0;
    logic in_req = 1'b0;

    // device transaction state
    int dev_pos = 0;
    logic [7:0] dev_op = 8'h00;
    logic [7:0] ld_hi = 8'h00;
    logic [15:0] cur_page = 16'h0000;
    int stall = 0;
    int nbytes = 0;

    int got_log[$];
    int exp_strm[$];
    int cyc = 0;
    logic cs_prev = 1'b1;
    logic prev_hold = 1'b0;
    logic [7:0] prev_data = 8'h00;
    logic prev_done = 1'b0;

    function automatic logic [1:0] ecc_of(input int pg);
        if (pg == fail_pg) return 2'(fail_code);
        if (pg == corr_pg) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [7:0] pat(input int pg, input int col);
        return 8'((pg * 37) + (col * 5) + (col >> 8));
    endfunction

    task automatic report(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // per-clock monitor, byte engine and device model
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cyc > 190000) begin
                errors++;
                $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 4 != 0) && (cyc % 7 != 0));
            if (prev_hold) begin
                report(out_valid && out_data == prev_data, "R7 held byte changed",
                       {out_valid, out_data}, {1'b1, prev_data});
            end
            if (out_valid && out_ready) begin
                if (exp_strm.size() == 0) begin
                    report(1'b0, "R7 unexpected stream byte", out_data, -1);
                end else begin
                    int e;
                    e = exp_strm.pop_front();
                    report(out_data == 8'(e), "R7 stream byte", out_data, e);
                end
            end
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
            if (out_valid && byte_req) report(1'b0, "R7 fetch while holding", 1, 0);
            if (prev_done && done) report(1'b0, "R9 done longer than one cycle", 1, 0);
            prev_done = done;
            if (err && !done) report(1'b0, "R9 err without done", 1, 0);
            if (in_req && req_ready) report(1'b0, "R10 ready while busy", 1, 0);
            if (!cs_prev && spi_cs_n) got_log.push_back(MARK);
            cs_prev = spi_cs_n;
            if (spi_cs_n) dev_pos = 0;
            if (byte_ack) begin
                byte_ack = 1'b0;
            end else if (byte_req && !spi_cs_n) begin
                if (stall > 0) begin
                    stall--;
                end else begin
                    logic [7:0] rx;
                    rx = 8'h00;
                    if (dev_pos == 0) dev_op = byte_tx;
                    if (dev_op == 8'h13 && dev_pos == 2) ld_hi = byte_tx;
                    if (dev_op == 8'h13 && dev_pos == 3) begin
                        cur_page = {ld_hi, byte_tx};
                        busy_left = int'(cur_page) % 3;
                    end
                    if (dev_op == 8'h05 && dev_pos == 2) begin
                        rx = {2'b00, ecc_of(int'(cur_page)), 3'b000, (busy_left > 0)};
                        if (busy_left > 0) busy_left--;
                    end
                    if (dev_op == 8'h0B && dev_pos >= 4) rx = pat(int'(cur_page), dev_pos - 4);
                    dev_pos++;
                    byte_rx = rx;
                    byte_ack = 1'b1;
                    got_log.push_back(int'(byte_tx));
                    nbytes++;
                    stall = (nbytes % 3 == 0) ? 1 : 0;
                end
            end
        end
    end

    task automatic push_status(ref int q[$]);
        q.push_back(8'h05); q.push_back(8'hC0); q.push_back(8'h00); q.push_back(MARK);
    endtask

    task automatic run_req(input int off, input int cnt, input int pre, input int fpg,
                           input int fcode, input int cpg, input int rmode, input string tag);
        int exp_log[$];
        bit exp_err;
        int pages;
        int pg;
        int waited;
        exp_log = {};
        exp_strm = {};
        got_log = {};
        fail_pg = fpg; fail_code = fcode; corr_pg = cpg; rdy_mode = rmode;
        busy_left = pre;
        exp_err = 1'b0;
        if ((off % PG) != 0 || (cnt % PG) != 0) begin
            exp_err = 1'b1;
        end else begin
            pages = cnt / PG;
            pg = (off / PG) & 16'hFFFF;
            for (int p = 0; p < pages; p++) begin
                for (int k = 0; k < ((p == 0) ? pre : 0) + 1; k++) push_status(exp_log);
                exp_log.push_back(8'h13); exp_log.push_back(8'h00);
                exp_log.push_back((pg >> 8) & 8'hFF); exp_log.push_back(pg & 8'hFF);
                exp_log.push_back(MARK);
                for (int k = 0; k < (pg % 3) + 1; k++) push_status(exp_log);
                exp_log.push_back(8'h0B);
                for (int k = 0; k < 3 + PG; k++) exp_log.push_back(8'h00);
                exp_log.push_back(MARK);
                for (int c = 0; c < PG; c++) exp_strm.push_back(int'(pat(pg, c)));
                push_status(exp_log);
                if (pg == fpg) begin
                    exp_err = 1'b1;
                    break;
                end
                pg = (pg + 1) & 16'hFFFF;
            end
        end
        @(negedge clk);
        req_offset = OFF_W'(off);
        req_count = CNT_W'(cnt);
        req_valid = 1'b1;
        @(negedge clk); #1;
        in_req = !done;
        // junk request while busy must be ignored (R10)
        req_offset = OFF_W'(PG * 9);
        req_count = CNT_W'(PG);
        waited = 0;
        while (!done && waited < 60000) begin
            if (waited == 20) req_valid = 1'b0;
            @(negedge clk); #1;
            waited++;
        end
        req_valid = 1'b0;
        in_req = 1'b0;
        report(done == 1'b1, {tag, " R9 done seen"}, done, 1);
        report(err == exp_err, {tag, " err at done"}, err, exp_err);
        report(got_log.size() == exp_log.size(), {tag, " transaction length"},
               got_log.size(), exp_log.size());
        begin
            int bad;
            bad = -1;
            for (int i = 0; i < exp_log.size() && i < got_log.size(); i++) begin
                if (bad < 0 && got_log[i] != exp_log[i]) bad = i;
            end
            report(bad < 0, {tag, " transaction bytes (first mismatch index)"}, bad, -1);
        end
        report(exp_strm.size() == 0, {tag, " stream bytes left unsent"}, exp_strm.size(), 0);
        @(negedge clk); #1;
        report(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
        report(req_ready == 1'b1, {tag, " R10 idle again"}, req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11 reset state
        report(spi_cs_n == 1'b1, "R11 cs_n after reset", spi_cs_n, 1);
        report(req_ready == 1'b1, "R11 req_ready after reset", req_ready, 1);
        report(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
        report(byte_req == 1'b0, "R11 byte_req after reset", byte_req, 0);
        report(done == 1'b0, "R11 done after reset", done, 0);

        run_req(100, PG, 0, -1, 2, -1, 0, "R1 misaligned offset");
        run_req(0, 1000, 0, -1, 2, -1, 0, "R1 misaligned count");
        run_req(PG * 4, 0, 0, -1, 2, -1, 0, "R2 zero count");
        run_req(PG * 5, PG, 2, -1, 2, -1, 0, "R3 R4 R5 R6 single page busy");
        run_req(PG * 16'h01FF, PG * 3, 0, -1, 2, 16'h0200, 1, "R4 R7 R8 index carry corrected");
        run_req(PG * 7, PG * 3, 1, 8, 2, -1, 1, "R8 code2 mid request");
        run_req(PG * 12, PG, 0, 12, 3, -1, 0, "R8 code3 first page");
        run_req(PG * 3, PG, 0, -1, 2, -1, 0, "R5 R10 after error");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule